// File: doc/BRIEF.md
# Next-Hop Adjacency Table

This block holds a table of next-hop entries for a router. Each entry carries a valid flag, an activity flag, an egress interface number, a trap action, a trap identifier and a 48-bit destination MAC address. The table has two ports. The management port accepts an operation code, a split index and the entry fields, and answers one cycle later with a status and read data. The lookup port accepts an index, answers one cycle later with a hit flag and the stored fields, and marks a hit entry as active.

Software ages next hops through the activity flag. A read can clear the flag, and a write can be made conditional on the flag being clear, which gives a race-free replace of idle entries. The conditional write returns no success indication, so a later read shows whether it took effect. When an entry is invalidated it goes into a fixed quarantine. During that window management accesses get a try-again status and lookups miss.

Top module: `nh_adj_table`

## Requirements
- R1: After reset every entry is invalid, inactive and out of quarantine. `mgmt_rsp_valid_o` and `lk_valid_o` are low until a request is made.
- R2: Every management request raises `mgmt_rsp_valid_o` exactly one cycle later, with a status from this set: 0 = OK, 1 = try again, 2 = out of range. Status 3 never occurs. A cycle with no request gives no response.
- R3: The management index is `{mgmt_idx_hi_i, mgmt_idx_lo_i}` (24 bits). An index of ENTRIES or more returns status 2 and changes no entry.
- R4: Operation 1 (write) stores the valid flag and fields. When the written valid flag is 1 it sets the activity flag, and when it is 0 it clears it. Operation 0 (read) returns valid, activity and fields without changing them.
- R5: Operation 2 (read and clear) returns the entry as it stood before the access, then clears its activity flag.
- R6: Operation 3 (conditional write) acts as operation 1 when the entry's activity flag is 0. When the flag is 1 it is dropped silently and still returns status 0.
- R7: A lookup of a valid entry returns hit = 1 and the entry's fields one cycle later, and sets the entry's activity flag. A lookup of an invalid, quarantined or out-of-range entry returns hit = 0 with all-zero fields, and sets no activity.
- R8: A read of an entry whose valid flag is 0 returns the interface, trap action, trap ID and MAC as zero.
- R9: A write that clears the valid flag of a valid entry starts a quarantine. Every management access to that entry in the QUAR_CYCLES cycles after the request returns status 1 and has no effect, and lookups of it miss. The next access after that window is served normally.
- R10: A write with valid = 1 and an egress interface of MAX_IFACE or more returns status 2 and changes nothing. Interface MAX_IFACE-1 is accepted.
- R11: When a management access and a lookup reach the same entry in the same cycle, the management effect comes first and the lookup's activity set follows. A read-and-clear that collides with a lookup hit therefore leaves the flag set. The lookup returns the contents from before the write.
- R12: Write responses and responses with a non-zero status return the valid, activity and all field outputs as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mgmt_req_i | input | 1 | Management request strobe |
| mgmt_op_i | input | 2 | Operation: 0 read, 1 write, 2 read and clear activity, 3 write if idle |
| mgmt_idx_lo_i | input | 16 | Index bits 15:0 |
| mgmt_idx_hi_i | input | 8 | Index bits 23:16 |
| mgmt_wr_valid_i | input | 1 | Valid flag to write |
| mgmt_wr_rif_i | input | 16 | Egress interface to write |
| mgmt_wr_action_i | input | 3 | Trap action to write (0 none, 1 trap, 2 mirror to CPU, 3 mirror, 4 discard errors) |
| mgmt_wr_trap_id_i | input | 8 | Trap ID to write |
| mgmt_wr_mac_i | input | 48 | Destination MAC to write |
| mgmt_rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| mgmt_status_o | output | 2 | 0 OK, 1 try again, 2 out of range |
| mgmt_rd_valid_o | output | 1 | Read valid flag |
| mgmt_rd_active_o | output | 1 | Read activity flag |
| mgmt_rd_rif_o | output | 16 | Read egress interface |
| mgmt_rd_action_o | output | 3 | Read trap action |
| mgmt_rd_trap_id_o | output | 8 | Read trap ID |
| mgmt_rd_mac_o | output | 48 | Read destination MAC |
| lk_req_i | input | 1 | Lookup request strobe |
| lk_idx_i | input | 24 | Lookup index |
| lk_valid_o | output | 1 | Lookup response strobe, one cycle after the request |
| lk_hit_o | output | 1 | Lookup hit |
| lk_rif_o | output | 16 | Egress interface of the hit entry |
| lk_action_o | output | 3 | Trap action of the hit entry |
| lk_trap_id_o | output | 8 | Trap ID of the hit entry |
| lk_mac_o | output | 48 | MAC of the hit entry |

## Verification
Both the management response and the lookup response are due exactly one rising edge after the request cycle. The bench drives each request at a falling edge and samples at the next falling edge, so each request is checked in its own cycle. Back-to-back requests let the quarantine be counted cycle by cycle: the QUAR_CYCLES requests right after the invalidating write must each see try again, and the one after must be served. Collision cases put a management request and a lookup in the same cycle, and the combined effect is read back on the following cycle.

// File: rtl/nh_adj_pkg.sv
package nh_adj_pkg;

    localparam int RIF_W  = 16;
    localparam int ACT_W  = 3;
    localparam int TID_W  = 8;
    localparam int MAC_W  = 48;
    localparam int IDXL_W = 16;
    localparam int IDXH_W = 8;
    localparam int IDX_W  = IDXL_W + IDXH_W;

    typedef enum logic [1:0] {
        OP_READ          = 2'd0,
        OP_WRITE         = 2'd1,
        OP_READ_CLR      = 2'd2,
        OP_WRITE_IF_IDLE = 2'd3
    } mgmt_op_e;

    typedef enum logic [1:0] {
        ST_OK    = 2'd0,
        ST_RETRY = 2'd1,
        ST_RANGE = 2'd2
    } mgmt_status_e;

    typedef struct packed {
        logic [RIF_W-1:0] rif;
        logic [ACT_W-1:0] action;
        logic [TID_W-1:0] trap_id;
        logic [MAC_W-1:0] mac;
    } payload_t;

    typedef struct packed {
        logic     v;
        logic     a;
        payload_t pl;
    } entry_t;

    // Reserved fields of an invalid entry are presented as zero.
    function automatic entry_t scrub(entry_t e);
        entry_t r;
        r = e;
        if (!e.v) r.pl = '0;
        return r;
    endfunction

endpackage

// File: rtl/nh_adj_quar.sv
module nh_adj_quar #(
    parameter int ENTRIES     = 256,
    parameter int QUAR_CYCLES = 16
) (
    input  logic                                     clk_i,
    input  logic                                     rst_ni,
    input  logic                                     start_i,
    input  logic [((ENTRIES > 1) ? $clog2(ENTRIES) : 1)-1:0] start_addr_i,
    output logic [ENTRIES-1:0]                       busy_o
);
    localparam int AW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int CW = $clog2(QUAR_CYCLES + 1);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cnt
        logic [CW-1:0] cnt_d, cnt_q;

        always_comb begin
            cnt_d = cnt_q;
            if (start_i && (start_addr_i == AW'(g))) begin
                cnt_d = CW'(QUAR_CYCLES);
            end else if (cnt_q != '0) begin
                cnt_d = cnt_q - 1'b1;
            end
        end

        always_ff @(posedge clk_i) begin
            if (!rst_ni) cnt_q <= '0;
            else         cnt_q <= cnt_d;
        end

        assign busy_o[g] = (cnt_q != '0);
    end
endmodule

// File: rtl/nh_adj_decode.sv
module nh_adj_decode
    import nh_adj_pkg::*;
#(
    parameter int MAX_IFACE = 1000
) (
    input  logic         req_i,
    input  logic [1:0]   op_i,
    input  logic         in_range_i,
    input  logic         busy_i,
    input  logic         cur_act_i,
    input  entry_t       req_ent_i,
    output mgmt_status_e status_o,
    output logic         wr_en_o,
    output logic         clr_o,
    output logic         rd_en_o,
    output entry_t       wr_ent_o
);
    mgmt_op_e op;
    logic     is_wr;
    logic     iface_bad;
    logic     ok;

    always_comb begin
        op        = mgmt_op_e'(op_i);
        is_wr     = (op == OP_WRITE) || (op == OP_WRITE_IF_IDLE);
        iface_bad = is_wr && req_ent_i.v &&
                    ({1'b0, req_ent_i.pl.rif} >= (RIF_W+1)'(MAX_IFACE));

        if (!in_range_i)    status_o = ST_RANGE;
        else if (busy_i)    status_o = ST_RETRY;
        else if (iface_bad) status_o = ST_RANGE;
        else                status_o = ST_OK;

        ok      = req_i && (status_o == ST_OK);
        wr_en_o = ok && is_wr && !((op == OP_WRITE_IF_IDLE) && cur_act_i);
        clr_o   = ok && (op == OP_READ_CLR);
        rd_en_o = ok && !is_wr;

        wr_ent_o   = scrub(req_ent_i);
        wr_ent_o.a = req_ent_i.v && req_ent_i.a;
    end
endmodule

// File: rtl/nh_adj_table.sv
module nh_adj_table
    import nh_adj_pkg::*;
#(
    parameter int ENTRIES     = 256,
    parameter int QUAR_CYCLES = 16,
    parameter int MAX_IFACE   = 1000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              mgmt_req_i,
    input  logic [1:0]        mgmt_op_i,
    input  logic [15:0]       mgmt_idx_lo_i,
    input  logic [7:0]        mgmt_idx_hi_i,
    input  logic              mgmt_wr_valid_i,
    input  logic [15:0]       mgmt_wr_rif_i,
    input  logic [2:0]        mgmt_wr_action_i,
    input  logic [7:0]        mgmt_wr_trap_id_i,
    input  logic [47:0]       mgmt_wr_mac_i,
    output logic              mgmt_rsp_valid_o,
    output logic [1:0]        mgmt_status_o,
    output logic              mgmt_rd_valid_o,
    output logic              mgmt_rd_active_o,
    output logic [15:0]       mgmt_rd_rif_o,
    output logic [2:0]        mgmt_rd_action_o,
    output logic [7:0]        mgmt_rd_trap_id_o,
    output logic [47:0]       mgmt_rd_mac_o,
    input  logic              lk_req_i,
    input  logic [23:0]       lk_idx_i,
    output logic              lk_valid_o,
    output logic              lk_hit_o,
    output logic [15:0]       lk_rif_o,
    output logic [2:0]        lk_action_o,
    output logic [7:0]        lk_trap_id_o,
    output logic [47:0]       lk_mac_o
);
    localparam int AW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic         rsp_valid;
        mgmt_status_e rsp_status;
        logic         rsp_v;
        logic         rsp_a;
        payload_t     rsp_pl;
        logic         lk_valid;
        logic         lk_hit;
        payload_t     lk_pl;
    } out_t;

    entry_t tbl_d [ENTRIES];
    entry_t tbl_q [ENTRIES];
    out_t   out_d, out_q;

    logic [IDX_W-1:0] m_idx;
    logic             m_in, l_in;
    logic [AW-1:0]    m_addr, l_addr;
    entry_t           cur_m, cur_l, req_ent, wr_ent, rd_ent;
    logic [ENTRIES-1:0] busy;
    mgmt_status_e     status;
    logic             wr_en, clr_act, rd_en, q_start, lk_hit;

    // Index decode shared by both ports
    always_comb begin
        m_idx  = {mgmt_idx_hi_i, mgmt_idx_lo_i};
        m_in   = (m_idx < IDX_W'(ENTRIES));
        l_in   = (lk_idx_i < IDX_W'(ENTRIES));
        m_addr = m_idx[AW-1:0];
        l_addr = lk_idx_i[AW-1:0];
        cur_m  = tbl_q[m_addr];
        cur_l  = tbl_q[l_addr];

        req_ent.v          = mgmt_wr_valid_i;
        req_ent.a          = 1'b1;
        req_ent.pl.rif     = mgmt_wr_rif_i;
        req_ent.pl.action  = mgmt_wr_action_i;
        req_ent.pl.trap_id = mgmt_wr_trap_id_i;
        req_ent.pl.mac     = mgmt_wr_mac_i;
    end

    nh_adj_decode #(.MAX_IFACE(MAX_IFACE)) u_dec (
        .req_i      (mgmt_req_i),
        .op_i       (mgmt_op_i),
        .in_range_i (m_in),
        .busy_i     (busy[m_addr]),
        .cur_act_i  (cur_m.a),
        .req_ent_i  (req_ent),
        .status_o   (status),
        .wr_en_o    (wr_en),
        .clr_o      (clr_act),
        .rd_en_o    (rd_en),
        .wr_ent_o   (wr_ent)
    );

    assign q_start = wr_en && cur_m.v && !wr_ent.v;
    assign lk_hit  = lk_req_i && l_in && cur_l.v && !busy[l_addr];
    assign rd_ent  = scrub(cur_m);

    nh_adj_quar #(.ENTRIES(ENTRIES), .QUAR_CYCLES(QUAR_CYCLES)) u_quar (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .start_i      (q_start),
        .start_addr_i (m_addr),
        .busy_o       (busy)
    );

    // Next-state: management effect first, then the lookup's activity set
    always_comb begin
        tbl_d = tbl_q;
        out_d = out_q;

        if (wr_en)   tbl_d[m_addr]   = wr_ent;
        if (clr_act) tbl_d[m_addr].a = 1'b0;
        if (lk_hit && tbl_d[l_addr].v) tbl_d[l_addr].a = 1'b1;

        out_d.rsp_valid  = mgmt_req_i;
        out_d.rsp_status = mgmt_req_i ? status : ST_OK;
        out_d.rsp_v      = rd_en && rd_ent.v;
        out_d.rsp_a      = rd_en && rd_ent.a;
        out_d.rsp_pl     = rd_en ? rd_ent.pl : '0;
        out_d.lk_valid   = lk_req_i;
        out_d.lk_hit     = lk_hit;
        out_d.lk_pl      = lk_hit ? cur_l.pl : '0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= '0;
            out_q <= '0;
        end else begin
            tbl_q <= tbl_d;
            out_q <= out_d;
        end
    end

    assign mgmt_rsp_valid_o  = out_q.rsp_valid;
    assign mgmt_status_o     = out_q.rsp_status;
    assign mgmt_rd_valid_o   = out_q.rsp_v;
    assign mgmt_rd_active_o  = out_q.rsp_a;
    assign mgmt_rd_rif_o     = out_q.rsp_pl.rif;
    assign mgmt_rd_action_o  = out_q.rsp_pl.action;
    assign mgmt_rd_trap_id_o = out_q.rsp_pl.trap_id;
    assign mgmt_rd_mac_o     = out_q.rsp_pl.mac;
    assign lk_valid_o        = out_q.lk_valid;
    assign lk_hit_o          = out_q.lk_hit;
    assign lk_rif_o          = out_q.lk_pl.rif;
    assign lk_action_o       = out_q.lk_pl.action;
    assign lk_trap_id_o      = out_q.lk_pl.trap_id;
    assign lk_mac_o          = out_q.lk_pl.mac;
endmodule

// File: rtl/nh_adj_table_chk.sv
module nh_adj_table_chk #(
    parameter int ENTRIES   = 256,
    parameter int MAX_IFACE = 1000
) (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        mgmt_req_i,
    input logic [1:0]  mgmt_op_i,
    input logic [15:0] mgmt_idx_lo_i,
    input logic [7:0]  mgmt_idx_hi_i,
    input logic        mgmt_wr_valid_i,
    input logic [15:0] mgmt_wr_rif_i,
    input logic        mgmt_rsp_valid_o,
    input logic [1:0]  mgmt_status_o,
    input logic        mgmt_rd_valid_o,
    input logic        mgmt_rd_active_o,
    input logic [15:0] mgmt_rd_rif_o,
    input logic [2:0]  mgmt_rd_action_o,
    input logic [7:0]  mgmt_rd_trap_id_o,
    input logic [47:0] mgmt_rd_mac_o,
    input logic        lk_req_i,
    input logic [23:0] lk_idx_i,
    input logic        lk_valid_o,
    input logic        lk_hit_o,
    input logic [15:0] lk_rif_o,
    input logic [47:0] lk_mac_o
);
    logic [23:0] m_idx;
    assign m_idx = {mgmt_idx_hi_i, mgmt_idx_lo_i};

    a_r2_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mgmt_req_i |=> mgmt_rsp_valid_o);

    a_r2_no_spurious_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mgmt_req_i |=> !mgmt_rsp_valid_o);

    a_r2_status_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mgmt_rsp_valid_o |-> (mgmt_status_o != 2'd3));

    a_r3_range_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mgmt_req_i && (m_idx >= 24'(ENTRIES))) |=> (mgmt_status_o == 2'd2));

    a_r10_iface_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mgmt_req_i && mgmt_op_i[0] && mgmt_wr_valid_i &&
         ({1'b0, mgmt_wr_rif_i} >= 17'(MAX_IFACE))) |=> (mgmt_status_o != 2'd0));

    a_r7_lk_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lk_req_i |=> lk_valid_o);

    a_r7_oor_lookup_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lk_req_i && (lk_idx_i >= 24'(ENTRIES))) |=> !lk_hit_o);

    a_r7_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lk_valid_o && !lk_hit_o) |-> ((lk_rif_o == '0) && (lk_mac_o == '0)));

    a_r8_invalid_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mgmt_rsp_valid_o && !mgmt_rd_valid_o) |->
        ((mgmt_rd_rif_o == '0) && (mgmt_rd_action_o == '0) &&
         (mgmt_rd_trap_id_o == '0) && (mgmt_rd_mac_o == '0)));

    a_r12_error_no_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mgmt_rsp_valid_o && (mgmt_status_o != 2'd0)) |->
        (!mgmt_rd_valid_o && !mgmt_rd_active_o && (mgmt_rd_mac_o == '0)));
endmodule

bind nh_adj_table nh_adj_table_chk #(.ENTRIES(ENTRIES), .MAX_IFACE(MAX_IFACE)) u_chk (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .mgmt_req_i        (mgmt_req_i),
    .mgmt_op_i         (mgmt_op_i),
    .mgmt_idx_lo_i     (mgmt_idx_lo_i),
    .mgmt_idx_hi_i     (mgmt_idx_hi_i),
    .mgmt_wr_valid_i   (mgmt_wr_valid_i),
    .mgmt_wr_rif_i     (mgmt_wr_rif_i),
    .mgmt_rsp_valid_o  (mgmt_rsp_valid_o),
    .mgmt_status_o     (mgmt_status_o),
    .mgmt_rd_valid_o   (mgmt_rd_valid_o),
    .mgmt_rd_active_o  (mgmt_rd_active_o),
    .mgmt_rd_rif_o     (mgmt_rd_rif_o),
    .mgmt_rd_action_o  (mgmt_rd_action_o),
    .mgmt_rd_trap_id_o (mgmt_rd_trap_id_o),
    .mgmt_rd_mac_o     (mgmt_rd_mac_o),
    .lk_req_i          (lk_req_i),
    .lk_idx_i          (lk_idx_i),
    .lk_valid_o        (lk_valid_o),
    .lk_hit_o          (lk_hit_o),
    .lk_rif_o          (lk_rif_o),
    .lk_mac_o          (lk_mac_o)
);

// File: tb/nh_adj_table_tb.sv
module nh_adj_table_tb_top;
    localparam int ENTRIES   = 256;
    localparam int QUAR      = 16;
    localparam int MAX_IFACE = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mgmt_req = 1'b0;
    logic [1:0]  mgmt_op = '0;
    logic [23:0] mgmt_idx = '0;
    logic        wr_v = 1'b0;
    logic [15:0] wr_rif = '0;
    logic [2:0]  wr_act = '0;
    logic [7:0]  wr_tid = '0;
    logic [47:0] wr_mac = '0;
    logic        lk_req = 1'b0;
    logic [23:0] lk_idx = '0;

    logic        rsp_valid, rd_valid, rd_active, lk_valid, lk_hit;
    logic [1:0]  status;
    logic [15:0] rd_rif, lk_rif;
    logic [2:0]  rd_act, lk_act;
    logic [7:0]  rd_tid, lk_tid;
    logic [47:0] rd_mac, lk_mac;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    nh_adj_table #(.ENTRIES(ENTRIES), .QUAR_CYCLES(QUAR), .MAX_IFACE(MAX_IFACE)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .mgmt_req_i(mgmt_req), .mgmt_op_i(mgmt_op),
        .mgmt_idx_lo_i(mgmt_idx[15:0]), .mgmt_idx_hi_i(mgmt_idx[23:16]),
        .mgmt_wr_valid_i(wr_v), .mgmt_wr_rif_i(wr_rif), .mgmt_wr_action_i(wr_act),
        .mgmt_wr_trap_id_i(wr_tid), .mgmt_wr_mac_i(wr_mac),
        .mgmt_rsp_valid_o(rsp_valid), .mgmt_status_o(status),
        .mgmt_rd_valid_o(rd_valid), .mgmt_rd_active_o(rd_active),
        .mgmt_rd_rif_o(rd_rif), .mgmt_rd_action_o(rd_act),
        .mgmt_rd_trap_id_o(rd_tid), .mgmt_rd_mac_o(rd_mac),
        .lk_req_i(lk_req), .lk_idx_i(lk_idx),
        .lk_valid_o(lk_valid), .lk_hit_o(lk_hit), .lk_rif_o(lk_rif),
        .lk_action_o(lk_act), .lk_trap_id_o(lk_tid), .lk_mac_o(lk_mac)
    );

    // Expected payload {rif, action, trap_id, mac} for sweep entry i
    function automatic logic [74:0] fld(int i);
        return {16'((i * 7) % MAX_IFACE), 3'(i % 5), 8'(i % 2), 8'hA5, 16'(i), 24'(i * i + 3)};
    endfunction

    task automatic chk(string tag, logic [95:0] actv, logic [95:0] expv);
        checks++;
        if (actv !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, actv, expv);
        end
    endtask

    // One cycle: drive at falling edge, return at next falling edge with the responses visible
    task automatic step(logic mr, logic [1:0] op, logic [23:0] idx, logic v, logic [74:0] f,
                        logic lr, logic [23:0] li);
        mgmt_req = mr; mgmt_op = op; mgmt_idx = idx; wr_v = v;
        {wr_rif, wr_act, wr_tid, wr_mac} = f;
        lk_req = lr; lk_idx = li;
        @(negedge clk);
        mgmt_req = 1'b0; lk_req = 1'b0;
    endtask

    task automatic mop(logic [1:0] op, int idx, logic v = 1'b0, logic [74:0] f = '0);
        step(1'b1, op, 24'(idx), v, f, 1'b0, '0);
    endtask

    task automatic exp_st(string tag, logic [1:0] st);
        chk(tag, {rsp_valid, status}, {1'b1, st});
    endtask

    task automatic exp_rd(string tag, logic ev, logic ea, logic [74:0] ef);
        exp_st(tag, 2'd0);
        chk(tag, {rd_valid, rd_active, rd_rif, rd_act, rd_tid, rd_mac}, {ev, ea, ef});
    endtask

    task automatic exp_zero_data(string tag);
        chk(tag, {rd_valid, rd_active, rd_rif, rd_act, rd_tid, rd_mac}, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [74:0] nf;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 outputs idle", {rsp_valid, lk_valid}, '0);
        mop(2'd0, 5);
        exp_rd("R1 R8 entry invalid after reset", 1'b0, 1'b0, '0);
        step(1'b0, 2'd0, '0, 1'b0, '0, 1'b0, '0);
        chk("R2 no request no response", {rsp_valid, lk_valid}, '0);

        // R4 sweep: write every entry, then read every entry
        for (int i = 0; i < ENTRIES; i++) begin
            mop(2'd1, i, 1'b1, fld(i));
            exp_st("R4 write status", 2'd0);
            if (i == 0) exp_zero_data("R12 write response data");
        end
        for (int i = 0; i < ENTRIES; i++) begin
            mop(2'd0, i);
            exp_rd("R4 sweep read", 1'b1, 1'b1, fld(i));
        end

        // R5 read and clear
        mop(2'd2, 10);
        exp_rd("R5 read-clear returns prior", 1'b1, 1'b1, fld(10));
        mop(2'd0, 10);
        exp_rd("R5 activity cleared", 1'b1, 1'b0, fld(10));

        // R6 conditional write
        nf = {16'd777, 3'd4, 8'd1, 48'h0123456789AB};
        mop(2'd3, 10, 1'b1, nf);
        exp_st("R6 cond write idle status", 2'd0);
        mop(2'd0, 10);
        exp_rd("R6 cond write applied on idle", 1'b1, 1'b1, nf);
        mop(2'd3, 11, 1'b1, nf);
        exp_st("R6 cond write busy status", 2'd0);
        mop(2'd0, 11);
        exp_rd("R6 cond write dropped when active", 1'b1, 1'b1, fld(11));

        // R7 lookup sets activity
        mop(2'd2, 12);
        step(1'b0, 2'd0, '0, 1'b0, '0, 1'b1, 24'd12);
        chk("R7 lookup hit", {lk_valid, lk_hit, lk_rif, lk_act, lk_tid, lk_mac}, {2'b11, fld(12)});
        mop(2'd0, 12);
        exp_rd("R7 lookup set activity", 1'b1, 1'b1, fld(12));
        step(1'b0, 2'd0, '0, 1'b0, '0, 1'b1, 24'd300);
        chk("R7 out-of-range lookup miss", {lk_valid, lk_hit, lk_rif, lk_act, lk_tid, lk_mac}, {2'b10, 75'd0});

        // R3 index range and concatenation
        mop(2'd1, 24'h010014, 1'b1, nf);
        exp_st("R3 high index part used", 2'd2);
        exp_zero_data("R12 error response data");
        mop(2'd0, 20);
        exp_rd("R3 out-of-range write no effect", 1'b1, 1'b1, fld(20));
        mop(2'd0, ENTRIES);
        exp_st("R3 index ENTRIES out of range", 2'd2);

        // R10 interface limit
        mop(2'd1, 30, 1'b1, {16'(MAX_IFACE), 3'd1, 8'd0, 48'hFFFF});
        exp_st("R10 interface at limit rejected", 2'd2);
        mop(2'd0, 30);
        exp_rd("R10 rejected write no effect", 1'b1, 1'b1, fld(30));
        nf = {16'(MAX_IFACE - 1), 3'd2, 8'd0, 48'h00000000BEEF};
        mop(2'd1, 30, 1'b1, nf);
        exp_st("R10 interface below limit accepted", 2'd0);
        mop(2'd0, 30);
        exp_rd("R10 accepted write stored", 1'b1, 1'b1, nf);

        // R9 quarantine
        mop(2'd1, 40, 1'b0, fld(40));
        exp_st("R9 invalidate status", 2'd0);
        for (int k = 1; k <= QUAR; k++) begin
            step(1'b1, (k == 5) ? 2'd1 : 2'd0, 24'd40, 1'b1, fld(41), 1'b1, 24'd40);
            exp_st("R9 quarantine retry", 2'd1);
            chk("R9 quarantine lookup miss", {lk_valid, lk_hit}, 2'b10);
        end
        mop(2'd0, 40);
        exp_rd("R9 R8 after quarantine invalid with zero fields", 1'b0, 1'b0, '0);
        step(1'b0, 2'd0, '0, 1'b0, '0, 1'b1, 24'd40);
        chk("R7 invalid entry lookup miss", {lk_valid, lk_hit, lk_mac}, {2'b10, 48'd0});
        mop(2'd0, 40);
        exp_rd("R7 miss sets no activity", 1'b0, 1'b0, '0);
        mop(2'd1, 40, 1'b1, fld(41));
        exp_st("R9 reuse after quarantine", 2'd0);
        mop(2'd0, 40);
        exp_rd("R9 reused entry", 1'b1, 1'b1, fld(41));

        // R11 collisions
        step(1'b1, 2'd2, 24'd50, 1'b0, '0, 1'b1, 24'd50);
        exp_rd("R11 read-clear with lookup", 1'b1, 1'b1, fld(50));
        chk("R11 collision lookup hit", {lk_valid, lk_hit}, 2'b11);
        mop(2'd0, 50);
        exp_rd("R11 activity kept", 1'b1, 1'b1, fld(50));
        step(1'b1, 2'd1, 24'd52, 1'b1, nf, 1'b1, 24'd52);
        chk("R11 lookup sees old contents", {lk_hit, lk_rif, lk_act, lk_tid, lk_mac}, {1'b1, fld(52)});
        mop(2'd0, 52);
        exp_rd("R11 write took effect", 1'b1, 1'b1, nf);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule